// File: doc/BRIEF.md
# PoE Powered-Device Discovery Sequencer

This block is the digital controller for the discovery phase of one power-sourcing network port. It sequences the analog probe sources through a two-point resistance measurement. If the measurement finds a valid signature, it can add a timed classification probe. It then raises a request to hand the port over to the power switch. Time is measured in ticks of an external 1 ms strobe. The probe currents arrive as unsigned digital codes from an external converter. The block samples each code at the end of its own phase. There is no handshake: the converter is expected to present a settled value whenever a phase ends.

Two readings set the measured resistance: the current at the 4 V probe (I1) and the current at the 8 V probe (I2). The resistance is the 4 V step divided by the current step. It is compared against an accept window using only multiplications. A failed measurement restarts detection. If collision avoidance is enabled, the output is first parked in high impedance for a back-off interval. A 3-bit status report shows that discovery is in progress, that a device was found without classification, or which class was measured.

Top module: `poe_disc_seq`

## Requirements
- R1: While `en` or `uv_ok` is low, the block leaves detection alone and does not start it. Dropping either input at any time makes `probe_sel` 0 (off) and `pwr_req` 0 on the next clock. It also returns the report to 111.
- R2: Once running, the block selects the 4 V probe (`probe_sel`=1) for DET_MS ticks and latches `det_code` on the last of them. It then selects the 8 V probe (`probe_sel`=2) for DET_MS ticks and takes the second sample on the last of them.
- R3: With ΔI = I2 − I1 (the detection code LSB is 1 µA), the detection is valid exactly when ΔI > 0 and 19 kΩ ≤ 4000 mV/ΔI ≤ 26.5 kΩ. This accepts ΔI from 151 to 210 and rejects every signature below 15 kΩ or above 33 kΩ.
- R4: After a failed detection, detection restarts at the 4 V probe. If `dca_en` is high, `probe_sel`=4 (high-Z) is held for BO_MS ticks before the restart.
- R5: After a valid detection with `cls_en` high, the block selects the 17.5 V probe (`probe_sel`=3) for CLS_MS ticks and samples `cls_code` on the last tick. It then raises `pwr_req`. With `cls_en` low it raises `pwr_req` directly, with `probe_sel`=0.
- R6: The `cls_code` LSB is 0.5 mA. The class report is 100 above 33 mA, 011 above 23 mA, 010 above 14.5 mA and 001 above 6.5 mA. It is 000 at or below 6.5 mA and also above 46.5 mA.
- R7: When power is requested without a classification phase, the report is 110.
- R8: If `det_dis` is high when the port starts, detection and classification are skipped whatever `cls_en` is. `pwr_req` rises on the next clock with report 110 and the probe never leaves off.
- R9: The report reads 111 from reset and throughout detection, back-off and classification, until a result is written on entry to power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle strobe per millisecond |
| en | input | 1 | Port enable |
| uv_ok | input | 1 | Supply above undervoltage threshold |
| cls_en | input | 1 | Classification phase enable |
| det_dis | input | 1 | Skip detection and classification |
| dca_en | input | 1 | Back-off after failed detection |
| det_code | input | DET_W | Detection current code, 1 µA per LSB |
| cls_code | input | CLS_W | Classification current code, 0.5 mA per LSB |
| probe_sel | output | 3 | 0 off, 1 4 V, 2 8 V, 3 17.5 V, 4 high-Z |
| cls_rpt | output | 3 | Discovery status / class report |
| pwr_req | output | 1 | Request to power up the port |

## Verification
The bench sweeps the current step across every value from a negative step to well beyond the 15 kΩ edge. It goes after the window edges at ΔI 150/151 and 210/211. A divider or rounding slip there would accept a 26.6 kΩ device or reject a 19.05 kΩ one. Every classification code is swept, so a band boundary shifted by one LSB, or a missing wrap to class 0 above 46.5 mA, shows as a wrong report. Phase lengths are counted in ticks to catch an off-by-one in the timers or a sample taken a phase late. Aborts in mid-detection and in power-up, undervoltage gating and the detection-skip path are also covered, since each could leave the probe driven or the power request stuck high.

// File: rtl/poe_disc_pkg.sv
package poe_disc_pkg;
  typedef enum logic [2:0] {
    PRB_OFF   = 3'd0,
    PRB_LOW   = 3'd1,
    PRB_HIGH  = 3'd2,
    PRB_CLASS = 3'd3,
    PRB_HIZ   = 3'd4
  } probe_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE1,
    ST_PROBE2,
    ST_CLASSIFY,
    ST_BACKOFF,
    ST_POWER
  } seq_e;

  localparam logic [2:0] RPT_BUSY    = 3'b111;
  localparam logic [2:0] RPT_NOCLASS = 3'b110;
endpackage

// File: rtl/poe_sig_window.sv
module poe_sig_window #(
  parameter int IW    = 10,
  parameter int DV_MV = 4000,
  parameter int RLO   = 38,
  parameter int RHI   = 53
) (
  input  logic [IW-1:0] i_first,
  input  logic [IW-1:0] i_second,
  output logic          ok
);
  // resistance limits in half-kilohm units; compare dI*R against 2*dV
  localparam int PW = IW + $clog2(RHI + 1) + $clog2(2 * DV_MV + 1) + 1;
  localparam logic [PW-1:0] TWO_DV = PW'(2 * DV_MV);

  logic [IW:0]   diff;
  logic [PW-1:0] lo_prod;
  logic [PW-1:0] hi_prod;
  logic          positive;

  assign diff     = {1'b0, i_second} - {1'b0, i_first};
  assign positive = !diff[IW] && (diff[IW-1:0] != '0);
  assign lo_prod  = PW'(diff[IW-1:0]) * PW'(RLO);
  assign hi_prod  = PW'(diff[IW-1:0]) * PW'(RHI);
  assign ok       = positive && (lo_prod <= TWO_DV) && (hi_prod >= TWO_DV);
endmodule

// File: rtl/poe_class_map.sv
module poe_class_map #(
  parameter int CW  = 8,
  parameter int T1  = 13,
  parameter int T2  = 29,
  parameter int T3  = 46,
  parameter int T4  = 66,
  parameter int T0  = 93
) (
  input  logic [CW-1:0] code,
  output logic [2:0]    cls
);
  localparam int NB = 4;
  localparam int TH [NB] = '{T1, T2, T3, T4};

  always_comb begin
    cls = 3'd0;
    for (int k = 0; k < NB; k++) begin
      if (int'(code) > TH[k]) cls = cls + 3'd1;
    end
    if (int'(code) > T0) cls = 3'd0;
  end
endmodule

// File: rtl/poe_disc_seq.sv
module poe_disc_seq
  import poe_disc_pkg::*;
#(
  parameter int DET_MS  = 88,
  parameter int CLS_MS  = 21,
  parameter int BO_MS   = 2800,
  parameter int DET_W   = 10,
  parameter int CLS_W   = 8,
  parameter int DV_MV   = 4000,
  parameter int R_LO_HK = 38,
  parameter int R_HI_HK = 53
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic             en,
  input  logic             uv_ok,
  input  logic             cls_en,
  input  logic             det_dis,
  input  logic             dca_en,
  input  logic [DET_W-1:0] det_code,
  input  logic [CLS_W-1:0] cls_code,
  output logic [2:0]       probe_sel,
  output logic [2:0]       cls_rpt,
  output logic             pwr_req
);
  localparam int MAX_A  = (DET_MS > CLS_MS) ? DET_MS : CLS_MS;
  localparam int MAXLEN = (MAX_A > BO_MS) ? MAX_A : BO_MS;
  localparam int TW     = $clog2(MAXLEN + 1);

  seq_e             st, st_nx;
  logic [TW-1:0]    tcnt, len_m1;
  logic [DET_W-1:0] i_first;
  logic [2:0]       rpt;
  logic [2:0]       cls_val;
  logic             det_ok, run, done;
  probe_e           prb;

  poe_sig_window #(.IW(DET_W), .DV_MV(DV_MV), .RLO(R_LO_HK), .RHI(R_HI_HK)) u_win (
    .i_first (i_first),
    .i_second(det_code),
    .ok      (det_ok)
  );

  poe_class_map #(.CW(CLS_W)) u_cls (
    .code(cls_code),
    .cls (cls_val)
  );

  assign run = en && uv_ok;

  always_comb begin
    case (st)
      ST_PROBE1, ST_PROBE2: len_m1 = TW'(DET_MS - 1);
      ST_CLASSIFY:          len_m1 = TW'(CLS_MS - 1);
      ST_BACKOFF:           len_m1 = TW'(BO_MS - 1);
      default:              len_m1 = '0;
    endcase
  end

  assign done = tick_ms && (tcnt == len_m1);

  always_comb begin
    st_nx = st;
    if (!run) begin
      st_nx = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE:     st_nx = det_dis ? ST_POWER : ST_PROBE1;
        ST_PROBE1:   if (done) st_nx = ST_PROBE2;
        ST_PROBE2:   if (done) begin
                       if (det_ok) st_nx = cls_en ? ST_CLASSIFY : ST_POWER;
                       else        st_nx = dca_en ? ST_BACKOFF : ST_PROBE1;
                     end
        ST_CLASSIFY: if (done) st_nx = ST_POWER;
        ST_BACKOFF:  if (done) st_nx = ST_PROBE1;
        default:     st_nx = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      tcnt    <= '0;
      i_first <= '0;
      rpt     <= RPT_BUSY;
    end else begin
      st <= st_nx;
      if (st_nx != st)                     tcnt <= '0;
      else if (tick_ms && tcnt != len_m1)  tcnt <= tcnt + 1'b1;
      if (st == ST_PROBE1 && done)         i_first <= det_code;
      if (st_nx == ST_IDLE)                rpt <= RPT_BUSY;
      else if (st_nx == ST_POWER && st != ST_POWER)
        rpt <= (st == ST_CLASSIFY) ? cls_val : RPT_NOCLASS;
    end
  end

  always_comb begin
    case (st)
      ST_PROBE1:   prb = PRB_LOW;
      ST_PROBE2:   prb = PRB_HIGH;
      ST_CLASSIFY: prb = PRB_CLASS;
      ST_BACKOFF:  prb = PRB_HIZ;
      default:     prb = PRB_OFF;
    endcase
  end

  assign probe_sel = prb;
  assign cls_rpt   = rpt;
  assign pwr_req   = (st == ST_POWER);

  a_r1_abort_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && uv_ok) |=> (probe_sel == 3'd0 && !pwr_req));

  a_r9_busy_report: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROBE1 || st == ST_PROBE2 || st == ST_BACKOFF || st == ST_CLASSIFY)
      |-> cls_rpt == RPT_BUSY);

  a_r7_power_has_result: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_req |-> cls_rpt != RPT_BUSY);

  a_r4_backoff_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROBE2 && st_nx == ST_BACKOFF) |-> (dca_en && !det_ok));

  a_r5_class_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CLASSIFY && $past(st) == ST_PROBE2) |-> $past(cls_en && det_ok));
endmodule

// File: tb/test_poe_disc_seq.sv
module test_poe_disc_seq;
  localparam int DET_MS = 4;
  localparam int CLS_MS = 3;
  localparam int BO_MS  = 6;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick_ms = 0, en = 0, uv_ok = 1, cls_en = 0, det_dis = 0, dca_en = 0;
  logic [9:0] det_code = '0;
  logic [7:0] cls_code = '0;
  logic [2:0] probe_sel, cls_rpt;
  logic       pwr_req;

  int n_checks = 0, n_fail = 0, phase = 0, cycles = 0;
  bit last_tick = 0;

  always #2 clk = ~clk;

  poe_disc_seq #(.DET_MS(DET_MS), .CLS_MS(CLS_MS), .BO_MS(BO_MS)) i_poe_disc_seq (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .en(en), .uv_ok(uv_ok),
    .cls_en(cls_en), .det_dis(det_dis), .dca_en(dca_en),
    .det_code(det_code), .cls_code(cls_code),
    .probe_sel(probe_sel), .cls_rpt(cls_rpt), .pwr_req(pwr_req)
  );

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
      finish_up();
    end
  end

  task automatic chk(input bit c, input string tag, input int act, input int exp);
    n_checks++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    tick_ms = (phase == 2);
    last_tick = tick_ms;
    phase = (phase + 1) % 3;
    @(posedge clk);
    #1;
  endtask

  task automatic wait_leave(input int p, output int t);
    int g = 0;
    t = 0;
    while (probe_sel == 3'(p) && g < 500) begin
      step();
      t += int'(last_tick);
      g++;
    end
    chk(g < 500, "R2 phase hang", g, 500);
  endtask

  function automatic int exp_class(input int cc);
    real ma = cc * 0.5;
    if (ma > 46.5) return 0;
    if (ma > 33.0) return 4;
    if (ma > 23.0) return 3;
    if (ma > 14.5) return 2;
    if (ma > 6.5)  return 1;
    return 0;
  endfunction

  task automatic trial(input int i1, input int i2, input int cc, input bit cen, input bit dca);
    int t, d;
    bit ok;
    en = 0; det_dis = 0; uv_ok = 1;
    step(); step();
    chk(probe_sel == 3'd0 && !pwr_req, "R1 disabled idle", probe_sel, 0);
    chk(cls_rpt == 3'b111, "R1 report reset", cls_rpt, 7);
    det_code = 10'(i1); cls_code = 8'(cc); cls_en = cen; dca_en = dca;
    en = 1;
    step();
    chk(probe_sel == 3'd1, "R2 low probe", probe_sel, 1);
    chk(cls_rpt == 3'b111, "R9 busy during detect", cls_rpt, 7);
    wait_leave(1, t);
    chk(t == DET_MS, "R2 low phase ticks", t, DET_MS);
    chk(probe_sel == 3'd2, "R2 high probe", probe_sel, 2);
    det_code = 10'(i2);
    wait_leave(2, t);
    chk(t == DET_MS, "R2 high phase ticks", t, DET_MS);
    d = i2 - i1;
    ok = (d > 0) && (4000.0 / d >= 19.0) && (4000.0 / d <= 26.5);
    chk((probe_sel != 3'd1 && probe_sel != 3'd4) == ok, "R3 accept window", d, int'(ok));
    if (ok && cen) begin
      chk(probe_sel == 3'd3, "R5 class probe", probe_sel, 3);
      chk(cls_rpt == 3'b111, "R9 busy during class", cls_rpt, 7);
      wait_leave(3, t);
      chk(t == CLS_MS, "R5 class ticks", t, CLS_MS);
      chk(pwr_req && probe_sel == 3'd0, "R5 power after class", pwr_req, 1);
      chk(cls_rpt == 3'(exp_class(cc)), "R6 class code", cls_rpt, exp_class(cc));
    end else if (ok) begin
      chk(pwr_req && probe_sel == 3'd0, "R5 direct power", pwr_req, 1);
      chk(cls_rpt == 3'b110, "R7 no-class report", cls_rpt, 6);
    end else begin
      chk(!pwr_req, "R3 reject no power", pwr_req, 0);
      chk(cls_rpt == 3'b111, "R9 busy after fail", cls_rpt, 7);
      if (dca) begin
        chk(probe_sel == 3'd4, "R4 backoff hiz", probe_sel, 4);
        wait_leave(4, t);
        chk(t == BO_MS, "R4 backoff ticks", t, BO_MS);
      end
      chk(probe_sel == 3'd1, "R4 retry low probe", probe_sel, 1);
    end
  endtask

  initial begin
    int t;
    step(); step();
    chk(probe_sel == 3'd0 && !pwr_req, "R1 reset outputs", probe_sel, 0);
    chk(cls_rpt == 3'b111, "R9 reset report", cls_rpt, 7);
    rst_n = 1;
    step();

    // undervoltage holds the port idle
    uv_ok = 0; en = 1;
    for (int k = 0; k < 12; k++) step();
    chk(probe_sel == 3'd0 && !pwr_req, "R1 undervoltage gating", probe_sel, 0);
    chk(cls_rpt == 3'b111, "R9 report while gated", cls_rpt, 7);
    uv_ok = 1;
    step();
    chk(probe_sel == 3'd1, "R1 start on supply good", probe_sel, 1);

    // step sweep across the window, varied modes
    for (int d = -5; d <= 300; d++)
      trial(100, 100 + d, 60, d % 2 == 0, d % 7 == 0);
    trial(0, 151, 20, 0, 0);
    trial(0, 150, 20, 0, 1);
    trial(700, 910, 20, 0, 0);
    trial(700, 911, 20, 0, 0);
    trial(800, 700, 20, 1, 1);

    // full classification code sweep
    for (int cc = 0; cc < 256; cc++)
      trial(50, 230, cc, 1, 0);

    // abort in middle of detection
    trial(10, 10, 0, 0, 0);
    wait_leave(1, t);
    chk(probe_sel == 3'd2, "R2 high before abort", probe_sel, 2);
    en = 0;
    step();
    chk(probe_sel == 3'd0 && cls_rpt == 3'b111, "R1 abort mid detect", probe_sel, 0);

    // abort from power
    trial(0, 180, 0, 0, 0);
    uv_ok = 0;
    step();
    chk(!pwr_req && probe_sel == 3'd0, "R1 abort from power", pwr_req, 0);
    chk(cls_rpt == 3'b111, "R1 report after abort", cls_rpt, 7);
    uv_ok = 1; en = 0;
    step();

    // detection skip
    det_dis = 1; cls_en = 1; det_code = 10'd0;
    en = 1;
    step();
    chk(pwr_req == 1'b1, "R8 skip to power", pwr_req, 1);
    chk(probe_sel == 3'd0, "R8 probe off", probe_sel, 0);
    chk(cls_rpt == 3'b110, "R8 skip report", cls_rpt, 6);
    for (int k = 0; k < 10; k++) step();
    chk(pwr_req && probe_sel == 3'd0, "R8 stays powered", pwr_req, 1);
    en = 0;
    step();
    chk(!pwr_req, "R1 disable after skip", pwr_req, 0);

    finish_up();
  end
endmodule